// File: doc/BRIEF.md
# Clock Gating Power Controller

This block gates the clocks of a chip from one register interface. Each peripheral clock has its own enable bit, and the bit position is the peripheral's identifier. A separate group of system enables covers the processor, the display, the USB host (one bit drives both host channels), the USB device and each programmable clock output. All enables are retimed on the falling edge of the reference clock and then ANDed with it. As a result, a gated clock always starts and stops on a full high phase.

A status word shows whether the main oscillator is ready, whether the master clock is settled, whether either PLL is locked, and whether each programmable clock is running. Any 0-to-1 change of a status bit latches a flag. The enabled flags drive a level interrupt, and reading the status word clears the flags. Software can put the processor into idle: its clock stops until an interrupt arrives. Only interrupts from peripherals whose clocks are still enabled count as a wake source, as does the block's own interrupt.

The master clock source and a power-of-two divider are selected through a configuration register. A new selection is held as pending until the chosen source reports ready, and only then takes effect. A power-down command forces the slow clock with no division.

Top module: `clk_gate_ctrl`

## Requirements
- R1: After reset the system enables read 0x1 (processor only) and every peripheral enable is 0. The master source is slow (0) with divider 0, irq_o is low, and the status word reads 0x02.
- R2: Writing to PER_SET (address 3) sets each peripheral enable whose data bit is 1. Writing to PER_CLR (address 4) clears each such enable. Zero bits have no effect. PER_STAT (address 5) returns the mask, and per_clk_en_o shows it by the falling edge after the write.
- R3: SYS_SET (address 0), SYS_CLR (address 1) and SYS_STAT (address 2) work the same way on the system enables. Bit 0 is the processor, bit 1 the display, bit 2 the USB host, bit 3 the USB device, and bit 4+k programmable clock k.
- R4: Every clock enable output changes only at a falling edge of clk_i.
- R5: STATUS (address 7) returns live levels. Bit 0 is the oscillator ready, bit 1 the master clock ready, bit 2 PLL A locked, bit 3 PLL B locked, and bit 4+k programmable clock k running.
- R6: A 0-to-1 change of a status bit sets its flag in FLAGS (address 9, reading it does not clear it); a 1-to-0 change sets nothing. irq_o is high while any flag is set whose bit is also set in IER (address 8).
- R7: Reading STATUS clears all flags, so irq_o falls in the next cycle.
- R8: Writing bit 0 = 1 to IDLE (address 10) gates the processor clock while SYS_STAT bit 0 stays 1. Either of two events re-enables it one cycle later: a per_irq_i bit whose peripheral clock is enabled, or irq_o.
- R9: A per_irq_i bit whose peripheral clock is disabled does not wake the processor.
- R10: A write to MCK_CFG (address 6) requests a new master setting: bits 1:0 select the source (0 slow, 1 main oscillator, 2 PLL A, 3 PLL B) and bits 3:2 the divider exponent. Until the chosen source is ready, the request stays pending, mck_src_o and mck_div_o keep their old values, status bit 1 reads 0, and MCK_CFG bit 8 reads 1. MCK_CFG bits 3:0 read back the applied setting.
- R11: Writing bit 0 = 1 to PDOWN (address 11) requests the slow source with divider 0. Because the slow clock is always ready, this takes effect on the next clock.
- R12: mck_ce_o is high on exactly one cycle in every 2^mck_div_o cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 write, 0 read |
| addr_i | input | 4 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid during the access cycle |
| osc_rdy_i | input | 1 | Main oscillator ready |
| plla_lock_i | input | 1 | PLL A locked |
| pllb_lock_i | input | 1 | PLL B locked |
| per_irq_i | input | N_PER | Peripheral interrupt requests |
| sys_clk_en_o | output | 4+N_PROG | Retimed system clock enables |
| sys_clk_o | output | 4+N_PROG | Gated system clocks |
| per_clk_en_o | output | N_PER | Retimed peripheral clock enables |
| per_clk_o | output | N_PER | Gated peripheral clocks |
| mck_src_o | output | 2 | Applied master clock source |
| mck_div_o | output | DIV_W | Applied divider exponent |
| mck_ce_o | output | 1 | Master clock enable pulse |
| irq_o | output | 1 | Controller interrupt |

## Verification
Most internal state can be seen at the ports within one cycle. A corrupted enable register shows on sys_clk_en_o or per_clk_en_o at the next falling edge. A bad edge detector or flag register shows on irq_o and FLAGS in the following cycle. A wrong idle state shows up only when an interrupt arrives, as a processor enable that stays low or comes back for a gated peripheral. A faulty switch sequencer shows as mck_src_o changing before the target is ready, or as the master-ready status bit not being cleared while a request is pending. Divider faults show only as a wrong pulse count on mck_ce_o over a 16-cycle window.

// File: rtl/cgc_pkg.sv
package cgc_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    RA_SYS_SET  = 4'h0,
    RA_SYS_CLR  = 4'h1,
    RA_SYS_STAT = 4'h2,
    RA_PER_SET  = 4'h3,
    RA_PER_CLR  = 4'h4,
    RA_PER_STAT = 4'h5,
    RA_MCK_CFG  = 4'h6,
    RA_STATUS   = 4'h7,
    RA_IER      = 4'h8,
    RA_FLAGS    = 4'h9,
    RA_IDLE     = 4'hA,
    RA_PDOWN    = 4'hB
  } reg_addr_e;

  typedef enum logic [1:0] {
    SRC_SLOW = 2'd0,
    SRC_MAIN = 2'd1,
    SRC_PLLA = 2'd2,
    SRC_PLLB = 2'd3
  } mck_src_e;

  localparam int ST_OSC  = 0;
  localparam int ST_MCK  = 1;
  localparam int ST_PLLA = 2;
  localparam int ST_PLLB = 3;
  localparam int ST_PROG = 4;
  localparam int SYS_CPU = 0;
  localparam int SYS_PROG = 4;
endpackage

// File: rtl/cgc_gate.sv
module cgc_gate #(
  parameter int          W       = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] en_i,
  output logic [W-1:0] en_o,
  output logic [W-1:0] clk_o
);
  logic [W-1:0] en_q;

  // retime on the low phase so the AND gate never clips a high pulse
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= RST_VAL;
    else         en_q <= en_i;
  end

  assign en_o = en_q;

  for (genvar g = 0; g < W; g++) begin : g_gate
    assign clk_o[g] = clk_i & en_q[g];
  end
endmodule

// File: rtl/cgc_regs.sv
module cgc_regs
  import cgc_pkg::*;
#(
  parameter int N_SYS  = 6,
  parameter int N_PER  = 16,
  parameter int N_STAT = 6,
  parameter int DIV_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_STAT-1:0] status_i,
  input  logic [N_STAT-1:0] flags_i,
  input  logic              wake_i,
  input  logic [1:0]        cur_src_i,
  input  logic [DIV_W-1:0]  cur_div_i,
  input  logic              pend_i,
  output logic [N_SYS-1:0]  sys_en_q,
  output logic [N_PER-1:0]  per_en_q,
  output logic [N_STAT-1:0] ier_q,
  output logic              idle_q,
  output logic              stat_rd_o,
  output logic              cfg_we_o,
  output logic [1:0]        cfg_src_o,
  output logic [DIV_W-1:0]  cfg_div_o,
  output logic              pdown_o
);
  logic wr, rd;
  assign wr = sel_i & we_i;
  assign rd = sel_i & ~we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sys_en_q <= N_SYS'(1);
      per_en_q <= '0;
      ier_q    <= '0;
      idle_q   <= 1'b0;
    end else begin
      if (wr && addr_i == RA_SYS_SET) sys_en_q <= sys_en_q | wdata_i[N_SYS-1:0];
      if (wr && addr_i == RA_SYS_CLR) sys_en_q <= sys_en_q & ~wdata_i[N_SYS-1:0];
      if (wr && addr_i == RA_PER_SET) per_en_q <= per_en_q | wdata_i[N_PER-1:0];
      if (wr && addr_i == RA_PER_CLR) per_en_q <= per_en_q & ~wdata_i[N_PER-1:0];
      if (wr && addr_i == RA_IER)     ier_q    <= wdata_i[N_STAT-1:0];
      if (wr && addr_i == RA_IDLE && wdata_i[0]) idle_q <= 1'b1;
      else if (wake_i)                           idle_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      RA_SYS_STAT: rdata_o[N_SYS-1:0]  = sys_en_q;
      RA_PER_STAT: rdata_o[N_PER-1:0]  = per_en_q;
      RA_STATUS:   rdata_o[N_STAT-1:0] = status_i;
      RA_IER:      rdata_o[N_STAT-1:0] = ier_q;
      RA_FLAGS:    rdata_o[N_STAT-1:0] = flags_i;
      RA_MCK_CFG: begin
        rdata_o[1:0]       = cur_src_i;
        rdata_o[2+:DIV_W]  = cur_div_i;
        rdata_o[8]         = pend_i;
      end
      default:     rdata_o = '0;
    endcase
  end

  assign stat_rd_o = rd && addr_i == RA_STATUS;
  assign cfg_we_o  = wr && addr_i == RA_MCK_CFG;
  assign cfg_src_o = wdata_i[1:0];
  assign cfg_div_o = wdata_i[2+:DIV_W];
  assign pdown_o   = wr && addr_i == RA_PDOWN && wdata_i[0];

  logic unused_wdata;
  assign unused_wdata = ^wdata_i;
endmodule

// File: rtl/cgc_stat.sv
module cgc_stat #(
  parameter int N_STAT = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_STAT-1:0] lvl_i,
  input  logic [N_STAT-1:0] ier_i,
  input  logic              rd_clr_i,
  output logic [N_STAT-1:0] flags_q,
  output logic              irq_o
);
  logic [N_STAT-1:0] prev_q, rise;

  assign rise = lvl_i & ~prev_q;

  // prev starts high: levels already set at reset raise no flag
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '1;
      flags_q <= '0;
    end else begin
      prev_q  <= lvl_i;
      flags_q <= rd_clr_i ? rise : (flags_q | rise);
    end
  end

  assign irq_o = |(flags_q & ier_i);
endmodule

// File: rtl/cgc_mck.sv
module cgc_mck
  import cgc_pkg::*;
#(
  parameter int DIV_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [1:0]       cfg_src_i,
  input  logic [DIV_W-1:0] cfg_div_i,
  input  logic             pdown_i,
  input  logic [3:0]       src_rdy_i,
  output logic [1:0]       cur_src_o,
  output logic [DIV_W-1:0] cur_div_o,
  output logic             pend_q,
  output logic [1:0]       req_src_q,
  output logic             ce_o
);
  localparam int CNT_W = (1 << DIV_W) - 1;

  logic [DIV_W-1:0] req_div_q;
  logic [CNT_W-1:0] cnt_q, mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_src_o <= SRC_SLOW;
      cur_div_o <= '0;
      req_src_q <= SRC_SLOW;
      req_div_q <= '0;
      pend_q    <= 1'b0;
    end else if (pdown_i) begin
      req_src_q <= SRC_SLOW;
      req_div_q <= '0;
      pend_q    <= 1'b1;
    end else if (cfg_we_i) begin
      req_src_q <= cfg_src_i;
      req_div_q <= cfg_div_i;
      pend_q    <= 1'b1;
    end else if (pend_q && src_rdy_i[req_src_q]) begin
      cur_src_o <= req_src_q;
      cur_div_o <= req_div_q;
      pend_q    <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    for (int i = 0; i < CNT_W; i++) mask[i] = (i < int'(cur_div_o));
  end

  assign ce_o = (cnt_q & mask) == '0;
endmodule

// File: rtl/clk_gate_ctrl.sv
module clk_gate_ctrl
  import cgc_pkg::*;
#(
  parameter int N_PER  = 16,
  parameter int N_PROG = 2,
  parameter int DIV_W  = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sel_i,
  input  logic                we_i,
  input  logic [3:0]          addr_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  input  logic                osc_rdy_i,
  input  logic                plla_lock_i,
  input  logic                pllb_lock_i,
  input  logic [N_PER-1:0]    per_irq_i,
  output logic [4+N_PROG-1:0] sys_clk_en_o,
  output logic [4+N_PROG-1:0] sys_clk_o,
  output logic [N_PER-1:0]    per_clk_en_o,
  output logic [N_PER-1:0]    per_clk_o,
  output logic [1:0]          mck_src_o,
  output logic [DIV_W-1:0]    mck_div_o,
  output logic                mck_ce_o,
  output logic                irq_o
);
  localparam int N_SYS  = 4 + N_PROG;
  localparam int N_STAT = 4 + N_PROG;

  logic [N_SYS-1:0]  sys_en_q, sys_req;
  logic [N_PER-1:0]  per_en_q;
  logic [N_STAT-1:0] ier_q, flags_q, status_lvl;
  logic              idle_q, stat_rd, cfg_we, pdown, pend_q, wake;
  logic [1:0]        cfg_src, req_src_q;
  logic [DIV_W-1:0]  cfg_div;
  logic [3:0]        src_rdy;

  assign src_rdy    = {pllb_lock_i, plla_lock_i, osc_rdy_i, 1'b1};
  assign status_lvl = {sys_clk_en_o[SYS_PROG+:N_PROG], pllb_lock_i, plla_lock_i,
                       ~pend_q, osc_rdy_i};
  assign sys_req    = {sys_en_q[N_SYS-1:1], sys_en_q[SYS_CPU] & ~idle_q};
  // gated peripherals cannot reach the wake logic
  assign wake       = (|(per_irq_i & per_clk_en_o)) | irq_o;

  cgc_regs #(.N_SYS(N_SYS), .N_PER(N_PER), .N_STAT(N_STAT), .DIV_W(DIV_W)) u_regs (
    .clk_i, .rst_ni, .sel_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .status_i(status_lvl), .flags_i(flags_q), .wake_i(wake),
    .cur_src_i(mck_src_o), .cur_div_i(mck_div_o), .pend_i(pend_q),
    .sys_en_q, .per_en_q, .ier_q, .idle_q,
    .stat_rd_o(stat_rd), .cfg_we_o(cfg_we), .cfg_src_o(cfg_src),
    .cfg_div_o(cfg_div), .pdown_o(pdown)
  );

  cgc_stat #(.N_STAT(N_STAT)) u_stat (
    .clk_i, .rst_ni, .lvl_i(status_lvl), .ier_i(ier_q),
    .rd_clr_i(stat_rd), .flags_q, .irq_o
  );

  cgc_mck #(.DIV_W(DIV_W)) u_mck (
    .clk_i, .rst_ni, .cfg_we_i(cfg_we), .cfg_src_i(cfg_src), .cfg_div_i(cfg_div),
    .pdown_i(pdown), .src_rdy_i(src_rdy), .cur_src_o(mck_src_o),
    .cur_div_o(mck_div_o), .pend_q, .req_src_q, .ce_o(mck_ce_o)
  );

  cgc_gate #(.W(N_SYS), .RST_VAL(N_SYS'(1))) u_sys_gate (
    .clk_i, .rst_ni, .en_i(sys_req), .en_o(sys_clk_en_o), .clk_o(sys_clk_o)
  );

  cgc_gate #(.W(N_PER), .RST_VAL('0)) u_per_gate (
    .clk_i, .rst_ni, .en_i(per_en_q), .en_o(per_clk_en_o), .clk_o(per_clk_o)
  );
endmodule

// File: rtl/cgc_chk.sv
module cgc_chk #(
  parameter int N_PER  = 16,
  parameter int N_STAT = 6,
  parameter int DIV_W  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              idle_q,
  input logic [N_PER-1:0]  per_en_q,
  input logic [N_PER-1:0]  per_clk_en_o,
  input logic              cpu_en_i,
  input logic              pend_q,
  input logic [1:0]        req_src_q,
  input logic [3:0]        src_rdy,
  input logic [1:0]        mck_src_o,
  input logic [DIV_W-1:0]  mck_div_o,
  input logic              mck_ce_o,
  input logic [N_STAT-1:0] status_lvl
);
  // R4: enable outputs move only on the falling edge
  a_r4_per_en_falling: assert property (@(negedge clk_i) disable iff (!rst_ni)
    per_clk_en_o == $past(per_en_q));

  a_r8_idle_cpu_off: assert property (@(negedge clk_i) disable iff (!rst_ni)
    $past(idle_q) |-> !cpu_en_i);

  a_r10_hold_until_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !src_rdy[req_src_q]) |=> ($stable(mck_src_o) && pend_q));

  a_r10_rdy_low_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> !status_lvl[1]);

  a_r10_switch_needs_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mck_src_o != $past(mck_src_o)) |-> $past(pend_q));

  a_r12_div0_every_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mck_div_o == '0) |-> mck_ce_o);
endmodule

bind clk_gate_ctrl cgc_chk #(.N_PER(N_PER), .N_STAT(N_STAT), .DIV_W(DIV_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .idle_q(idle_q), .per_en_q(per_en_q),
  .per_clk_en_o(per_clk_en_o), .cpu_en_i(sys_clk_en_o[0]), .pend_q(pend_q),
  .req_src_q(req_src_q), .src_rdy(src_rdy), .mck_src_o(mck_src_o),
  .mck_div_o(mck_div_o), .mck_ce_o(mck_ce_o), .status_lvl(status_lvl)
);

// File: tb/tb_clk_gate_ctrl.sv
`timescale 1ns/1ps
module tb_clk_gate_ctrl;
  localparam int N_PER = 16;
  localparam int N_PROG = 2;
  localparam int DIV_W = 2;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sel_i = 1'b0, we_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        osc_rdy_i = 1'b0, plla_lock_i = 1'b0, pllb_lock_i = 1'b0;
  logic [N_PER-1:0] per_irq_i = '0;
  logic [4+N_PROG-1:0] sys_clk_en_o, sys_clk_o;
  logic [N_PER-1:0] per_clk_en_o, per_clk_o;
  logic [1:0] mck_src_o;
  logic [DIV_W-1:0] mck_div_o;
  logic mck_ce_o, irq_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  clk_gate_ctrl #(.N_PER(N_PER), .N_PROG(N_PROG), .DIV_W(DIV_W)) dut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // lands 3 ns after a rising edge: past the falling-edge retiming
  task automatic cyc();
    @(posedge clk_i);
    #3;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    sel_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    cyc();
    sel_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    sel_i = 1'b1; we_i = 1'b0; addr_i = a;
    #1 d = rdata_o;
    cyc();
    sel_i = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 sys en", 32'(sys_clk_en_o), 32'h1);
    check("R1 per en", 32'(per_clk_en_o), 32'h0);
    check("R1 mck src", 32'(mck_src_o), 32'h0);
    check("R1 irq", 32'(irq_o), 32'h0);
    rd(4'h7, d); check("R1 status", d, 32'h02);
  endtask

  task automatic t_periph();
    logic [31:0] d;
    wr(4'h3, 32'h0005); check("R2 set", 32'(per_clk_en_o), 32'h0005);
    wr(4'h3, 32'h0100); check("R2 set keeps", 32'(per_clk_en_o), 32'h0105);
    wr(4'h4, 32'h0004); check("R2 clr", 32'(per_clk_en_o), 32'h0101);
    wr(4'h4, 32'h0000); check("R2 zero clr", 32'(per_clk_en_o), 32'h0101);
    rd(4'h5, d); check("R2 readback", d, 32'h0101);
  endtask

  task automatic t_sys();
    logic [31:0] d;
    wr(4'h0, 32'h1E); check("R3 set", 32'(sys_clk_en_o), 32'h1F);
    wr(4'h1, 32'h06); check("R3 clr", 32'(sys_clk_en_o), 32'h19);
    rd(4'h2, d); check("R3 readback", d, 32'h19);
    wr(4'h1, 32'h30); check("R3 prog off", 32'(sys_clk_en_o), 32'h09);
    rd(4'h7, d);
  endtask

  task automatic t_status();
    logic [31:0] d;
    wr(4'h8, 32'h0D);
    check("R6 no irq", 32'(irq_o), 32'h0);
    osc_rdy_i = 1'b1;
    cyc(); check("R6 rise irq", 32'(irq_o), 32'h1);
    rd(4'h9, d); check("R6 flags", d, 32'h01);
    rd(4'h7, d); check("R5 levels", d, 32'h03);
    check("R7 clear irq", 32'(irq_o), 32'h0);
    rd(4'h9, d); check("R7 flags cleared", d, 32'h00);
    osc_rdy_i = 1'b0;
    cyc(); cyc();
    check("R6 fall no irq", 32'(irq_o), 32'h0);
    rd(4'h9, d); check("R6 fall no flag", d, 32'h00);
    wr(4'h0, 32'h10); cyc();
    check("R6 masked", 32'(irq_o), 32'h0);
    rd(4'h9, d); check("R5 prog flag", d, 32'h10);
    wr(4'h1, 32'h10); rd(4'h7, d);
  endtask

  task automatic t_idle();
    logic [31:0] d;
    wr(4'hA, 32'h1);
    check("R8 cpu gated", 32'(sys_clk_en_o[0]), 32'h0);
    rd(4'h2, d); check("R8 stat keeps", d, 32'h09);
    per_irq_i = 16'h0002;
    cyc(); cyc();
    check("R9 gated irq no wake", 32'(sys_clk_en_o[0]), 32'h0);
    per_irq_i = 16'h0100;
    cyc(); check("R8 wake", 32'(sys_clk_en_o[0]), 32'h1);
    per_irq_i = '0;
    wr(4'h8, 32'h01);
    wr(4'hA, 32'h1);
    check("R8 gated again", 32'(sys_clk_en_o[0]), 32'h0);
    osc_rdy_i = 1'b1;
    cyc(); cyc();
    check("R8 own irq wake", 32'(sys_clk_en_o[0]), 32'h1);
    rd(4'h7, d);
  endtask

  task automatic t_mck();
    logic [31:0] d;
    wr(4'h6, 32'h6);
    rd(4'h7, d); check("R10 rdy low pending", d, 32'h01);
    rd(4'h6, d); check("R10 pending cfg", d, 32'h100);
    wr(4'h8, 32'h02);
    cyc(); cyc();
    check("R10 held src", 32'(mck_src_o), 32'h0);
    plla_lock_i = 1'b1;
    cyc();
    check("R10 applied src", 32'(mck_src_o), 32'h2);
    check("R10 applied div", 32'(mck_div_o), 32'h1);
    cyc(); check("R10 ready irq", 32'(irq_o), 32'h1);
    rd(4'h7, d); check("R10 status", d, 32'h07);
    rd(4'h6, d); check("R10 cfg read", d, 32'h006);
    wr(4'h6, 32'h1); cyc();
    check("R10 main src", 32'(mck_src_o), 32'h1);
  endtask

  task automatic t_div();
    int cnt = 0;
    wr(4'h6, 32'h9); cyc();
    check("R12 div set", 32'(mck_div_o), 32'h2);
    for (int i = 0; i < 16; i++) begin
      if (mck_ce_o) cnt++;
      cyc();
    end
    check("R12 ce count", 32'(cnt), 32'd4);
  endtask

  task automatic t_pdown();
    logic [31:0] d;
    wr(4'hB, 32'h1); cyc();
    check("R11 slow src", 32'(mck_src_o), 32'h0);
    check("R11 div0", 32'(mck_div_o), 32'h0);
    rd(4'h6, d); check("R11 cfg", d, 32'h0);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #3 rst_ni = 1'b1;
    cyc();
    t_reset();
    t_periph();
    t_sys();
    t_status();
    t_idle();
    t_mck();
    t_div();
    t_pdown();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule